// File: doc/BRIEF.md
# PWM Compare-and-Action Channel

This block is one compare/output channel hung off a shared 16-bit PWM timebase. It does not count. It watches the counter value and the zero and period strobes that the timebase supplies, and it compares the counter against two programmable compare values, A and B. It then drives two PWM output pins. Each pin has its own small table that says what a compare-A match, a compare-B match, a counter-zero event or a period event does to it: set, clear, toggle or nothing.

Both compare values can be double-buffered. With buffering on, software writes land in a holding register and reach the comparator only at the next counter-zero tick, so a duty-cycle change never splits a PWM period. With buffering off, a write takes effect at once. Every event is qualified by the timebase tick enable, so a counter value that is held for several clocks by a prescaler produces only one event.

Software programs the channel through a simple write port: a 2-bit register select, 16 bits of data and a write strobe.

Top module: `pwm_action_chan`

## Requirements
- R1: While reset is asserted, and after it is released, `pwmOut` is 0 and `matchA`/`matchB` are 0. All action fields reset to no action (00), both compare values reset to 0, and buffering is off.
- R2: `matchA` (or `matchB`) is high for exactly one clock, on the clock after a cycle in which `tickEn` is high and `cntVal` equals the active compare-A (or compare-B) value.
- R3: Action codes are 00 no action, 01 clear, 10 set and 11 toggle. The chosen action shows on the pin one clock after the tick that carries the event.
- R4: Register select 0 writes compare A and select 1 writes compare B. Select 2 writes the action table: output k uses bits [8k+1:8k] for zero, [8k+3:8k+2] for period, [8k+5:8k+4] for compare A and [8k+7:8k+6] for compare B. Select 3 sets buffering, with bit 0 for A and bit 1 for B. A write alone never changes `pwmOut`.
- R5: When several events occur in one tick, each output applies only the highest-priority event whose action is not 00. The order, highest first, is zero, period, compare A, compare B. An event coded 00 lets a lower-priority event through.
- R6: With buffering off, a written compare value is used from the next clock.
- R7: With buffering on, a written compare value is used only after a tick that carries a zero event. The compare made during that zero tick still uses the previous value.
- R8: While `tickEn` is low, zero, period and compare events have no effect: no output change, no match strobe and no buffered load.
- R9: The two outputs follow their own action tables, so the same event can drive them in different directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntVal | input | 16 | Current timebase counter value |
| tickEn | input | 1 | Timebase tick enable; qualifies every event |
| zeroEvt | input | 1 | Counter-zero strobe from the timebase |
| prdEvt | input | 1 | Counter period/overflow strobe from the timebase |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (see R4) |
| wrData | input | 16 | Register write data |
| pwmOut | output | 2 | PWM output pins, bit k is output k |
| matchA | output | 1 | Compare-A match strobe |
| matchB | output | 1 | Compare-B match strobe |

## Verification
Each pin and match result becomes visible one clock edge after the tick that produces it. A register write affects comparisons from the edge that stores it, and a buffered load takes effect one edge after the zero tick. The bench applies each stimulus at a falling edge and compares all three results at the next falling edge, so exactly one rising edge separates cause from check. The buffered cases insert a zero tick between the write and the probing tick, which catches any slip of one cycle in the load.

// File: rtl/pwm_action_pkg.sv
package pwm_action_pkg;

  localparam int EVT_N  = 4;                 // events per output
  localparam int ACT_W  = 2;                 // bits per action code
  localparam int SLICE_W = EVT_N * ACT_W;    // table bits per output

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // qualified events handed from the datapath to the control
  typedef struct packed {
    logic zero;
    logic prd;
    logic cmpA;
    logic cmpB;
  } evtStrb_t;

  localparam logic [1:0] ADR_CMPA = 2'd0;
  localparam logic [1:0] ADR_CMPB = 2'd1;
  localparam logic [1:0] ADR_ACT  = 2'd2;
  localparam logic [1:0] ADR_SHD  = 2'd3;

  // lowest priority first, later hits overwrite earlier ones
  function automatic act_e pickAct(evtStrb_t e, logic [SLICE_W-1:0] tbl);
    act_e res;
    res = ACT_NONE;
    if (e.cmpB && tbl[7:6] != 2'b00) res = act_e'(tbl[7:6]);
    if (e.cmpA && tbl[5:4] != 2'b00) res = act_e'(tbl[5:4]);
    if (e.prd  && tbl[3:2] != 2'b00) res = act_e'(tbl[3:2]);
    if (e.zero && tbl[1:0] != 2'b00) res = act_e'(tbl[1:0]);
    return res;
  endfunction

  function automatic logic applyAct(act_e a, logic cur);
    logic nxt;
    case (a)
      ACT_CLR: nxt = 1'b0;
      ACT_SET: nxt = 1'b1;
      ACT_TGL: nxt = ~cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_action_dp.sv
module pwm_action_dp
  import pwm_action_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CntW-1:0] cntVal,
  input  logic            tickEn,
  input  logic            zeroEvt,
  input  logic            prdEvt,
  input  logic            wrEn,
  input  logic [1:0]      wrAddr,
  input  logic [CntW-1:0] wrData,
  output evtStrb_t        evt,
  output logic            matchA,
  output logic            matchB
);

  localparam int NumCmp = 2;

  logic [NumCmp-1:0] shdEn;
  logic [NumCmp-1:0] hit;
  logic              zeroTick;

  assign zeroTick = tickEn & zeroEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            shdEn <= '0;
    else if (wrEn && wrAddr == ADR_SHD)   shdEn <= wrData[NumCmp-1:0];
  end

  for (genvar g = 0; g < NumCmp; g++) begin : gCmp
    logic [CntW-1:0] holdVal;
    logic [CntW-1:0] liveVal;
    logic            wrHit;

    assign wrHit = wrEn && (wrAddr == 2'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdVal <= '0;
        liveVal <= '0;
      end else begin
        if (wrHit) holdVal <= wrData;
        if (wrHit && !shdEn[g])          liveVal <= wrData;
        else if (shdEn[g] && zeroTick)   liveVal <= holdVal;
      end
    end

    assign hit[g] = tickEn && (cntVal == liveVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchA <= 1'b0;
      matchB <= 1'b0;
    end else begin
      matchA <= hit[0];
      matchB <= hit[1];
    end
  end

  always_comb begin
    evt.zero = zeroTick;
    evt.prd  = tickEn & prdEvt;
    evt.cmpA = hit[0];
    evt.cmpB = hit[1];
  end

endmodule

// File: rtl/pwm_action_ctl.sv
module pwm_action_ctl
  import pwm_action_pkg::*;
#(
  parameter int NumOut = 2,
  parameter int CntW   = 16,
  localparam int TblW  = NumOut * SLICE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrb_t          evt,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CntW-1:0]   wrData,
  output logic [NumOut-1:0] pwmOut,
  output logic [TblW-1:0]   actTbl
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           actTbl <= '0;
    else if (wrEn && wrAddr == ADR_ACT)  actTbl <= wrData[TblW-1:0];
  end

  for (genvar o = 0; o < NumOut; o++) begin : gOut
    logic [SLICE_W-1:0] slice;
    act_e               act;
    logic               outQ;

    assign slice = actTbl[o*SLICE_W +: SLICE_W];
    assign act   = pickAct(evt, slice);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outQ <= 1'b0;
      else       outQ <= applyAct(act, outQ);
    end

    assign pwmOut[o] = outQ;
  end

endmodule

// File: rtl/pwm_action_chan.sv
module pwm_action_chan
  import pwm_action_pkg::*;
#(
  parameter int NumOut = 2,
  parameter int CntW   = 16,
  localparam int TblW  = NumOut * SLICE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CntW-1:0]   cntVal,
  input  logic              tickEn,
  input  logic              zeroEvt,
  input  logic              prdEvt,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CntW-1:0]   wrData,
  output logic [NumOut-1:0] pwmOut,
  output logic              matchA,
  output logic              matchB
);

  evtStrb_t        evt;
  logic [TblW-1:0] actTbl;

  pwm_action_dp #(.CntW(CntW)) uDp (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .tickEn(tickEn),
    .zeroEvt(zeroEvt), .prdEvt(prdEvt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .evt(evt), .matchA(matchA), .matchB(matchB)
  );

  pwm_action_ctl #(.NumOut(NumOut), .CntW(CntW)) uCtl (
    .clk(clk), .rstN(rstN), .evt(evt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .actTbl(actTbl)
  );

endmodule

// File: rtl/pwm_action_chan_chk.sv
module pwm_action_chan_chk #(
  parameter int NumOut = 2,
  parameter int TblW   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              zeroEvt,
  input logic              matchA,
  input logic              matchB,
  input logic [NumOut-1:0] pwmOut,
  input logic [TblW-1:0]   actTbl
);

  localparam int HiBase = (NumOut - 1) * 8;

  // R2: a match strobe only follows a ticking cycle
  p_match_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (matchA || matchB) |-> $past(tickEn));

  // R8: no tick, no strobe on the next clock
  p_idle_nomatch_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> !(matchA || matchB));

  // R8: no tick, pins hold on the next clock
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(pwmOut));

  // R5: zero is top priority, a set on it must win
  p_zero_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && zeroEvt && actTbl[1:0] == 2'b10) |=> pwmOut[0]);

  // R5: zero clear on the last output must win
  p_zero_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && zeroEvt && actTbl[HiBase +: 2] == 2'b01) |=> !pwmOut[NumOut-1]);

  // R3: toggle code inverts the pin
  p_zero_tgl_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && zeroEvt && actTbl[1:0] == 2'b11) |=> pwmOut[0] != $past(pwmOut[0]));

endmodule

bind pwm_action_chan pwm_action_chan_chk #(.NumOut(NumOut), .TblW(TblW)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .zeroEvt(zeroEvt),
  .matchA(matchA), .matchB(matchB), .pwmOut(pwmOut), .actTbl(actTbl)
);

// File: tb/pwm_action_chan_test.sv
module pwm_action_chan_test;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 46;
  localparam int NV = 31;

  // {tag, wr, addr, data, tick, cnt, zero, prd, expPwm, expMA, expMB}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd4, 1'b1, 2'd0, 16'd100,   1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R4 cmpA
    {4'd4, 1'b1, 2'd1, 16'd200,   1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R4 cmpB
    {4'd4, 1'b1, 2'd2, 16'h6112,  1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R4 table
    {4'd3, 1'b0, 2'd0, 16'd0,     1'b1, 16'd0,   1'b1, 1'b0, 2'b01, 1'b0, 1'b0}, // R3 zero set/clr
    {4'd3, 1'b0, 2'd0, 16'd0,     1'b1, 16'd50,  1'b0, 1'b0, 2'b01, 1'b0, 1'b0}, // R3 quiet
    {4'd2, 1'b0, 2'd0, 16'd0,     1'b1, 16'd100, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0}, // R2 A hit
    {4'd8, 1'b0, 2'd0, 16'd0,     1'b0, 16'd200, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0}, // R8 no tick
    {4'd2, 1'b0, 2'd0, 16'd0,     1'b1, 16'd200, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1}, // R2 B hit
    {4'd3, 1'b0, 2'd0, 16'd0,     1'b1, 16'd300, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0}, // R3 no-op prd
    {4'd4, 1'b1, 2'd2, 16'h366C,  1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R4 table 2
    {4'd5, 1'b0, 2'd0, 16'd0,     1'b1, 16'd100, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0}, // R5 prd over A
    {4'd5, 1'b0, 2'd0, 16'd0,     1'b1, 16'd100, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0}, // R5 no-op falls through
    {4'd9, 1'b0, 2'd0, 16'd0,     1'b1, 16'd100, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0}, // R9 set vs toggle
    {4'd9, 1'b0, 2'd0, 16'd0,     1'b1, 16'd200, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1}, // R9 clr vs none
    {4'd3, 1'b0, 2'd0, 16'd0,     1'b1, 16'd5,   1'b0, 1'b1, 2'b01, 1'b0, 1'b0}, // R3 toggle up
    {4'd3, 1'b0, 2'd0, 16'd0,     1'b1, 16'd5,   1'b0, 1'b1, 2'b00, 1'b0, 1'b0}, // R3 toggle down
    {4'd7, 1'b1, 2'd3, 16'd3,     1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R7 buffer on
    {4'd7, 1'b1, 2'd0, 16'd7,     1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R7 write held
    {4'd7, 1'b0, 2'd0, 16'd0,     1'b1, 16'd7,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R7 new not live
    {4'd7, 1'b0, 2'd0, 16'd0,     1'b1, 16'd100, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0}, // R7 old live
    {4'd7, 1'b0, 2'd0, 16'd0,     1'b1, 16'd0,   1'b1, 1'b0, 2'b11, 1'b0, 1'b0}, // R7 load tick
    {4'd7, 1'b0, 2'd0, 16'd0,     1'b1, 16'd7,   1'b0, 1'b0, 2'b01, 1'b1, 1'b0}, // R7 new live
    {4'd7, 1'b0, 2'd0, 16'd0,     1'b1, 16'd100, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0}, // R7 old gone
    {4'd6, 1'b1, 2'd3, 16'd0,     1'b0, 16'd0,   1'b0, 1'b0, 2'b01, 1'b0, 1'b0}, // R6 buffer off
    {4'd6, 1'b1, 2'd1, 16'd9,     1'b0, 16'd0,   1'b0, 1'b0, 2'b01, 1'b0, 1'b0}, // R6 direct B
    {4'd6, 1'b0, 2'd0, 16'd0,     1'b1, 16'd9,   1'b0, 1'b0, 2'b00, 1'b0, 1'b1}, // R6 B live
    {4'd8, 1'b1, 2'd3, 16'd1,     1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R8 buffer A
    {4'd8, 1'b1, 2'd0, 16'd40,    1'b0, 16'd0,   1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R8 write held
    {4'd8, 1'b0, 2'd0, 16'd0,     1'b0, 16'd0,   1'b1, 1'b0, 2'b00, 1'b0, 1'b0}, // R8 zero w/o tick
    {4'd8, 1'b0, 2'd0, 16'd0,     1'b1, 16'd40,  1'b0, 1'b0, 2'b00, 1'b0, 1'b0}, // R8 no load
    {4'd8, 1'b0, 2'd0, 16'd0,     1'b1, 16'd7,   1'b0, 1'b0, 2'b11, 1'b1, 1'b0}  // R8 old kept
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cntVal;
  logic        tickEn, zeroEvt, prdEvt, wrEn;
  logic [1:0]  wrAddr;
  logic [15:0] wrData;
  logic [1:0]  pwmOut;
  logic        matchA, matchB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_action_chan uut (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .tickEn(tickEn),
    .zeroEvt(zeroEvt), .prdEvt(prdEvt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .matchA(matchA), .matchB(matchB)
  );

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrAddr = 0; wrData = 0;
    tickEn = 0; cntVal = 0; zeroEvt = 0; prdEvt = 0;
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset pwmOut", int'(pwmOut), 0);
    check("R1 reset matchA", int'(matchA), 0);
    check("R1 reset matchB", int'(matchB), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      wrEn = v[41]; wrAddr = v[40:39]; wrData = v[38:23];
      tickEn = v[22]; cntVal = v[21:6]; zeroEvt = v[5]; prdEvt = v[4];
      @(negedge clk);
      check($sformatf("R%0d vec %0d pwmOut", v[45:42], i), int'(pwmOut), int'(v[3:2]));
      check($sformatf("R%0d vec %0d matchA", v[45:42], i), int'(matchA), int'(v[1]));
      check($sformatf("R%0d vec %0d matchB", v[45:42], i), int'(matchB), int'(v[0]));
    end

    // R1: reset in mid-run clears driven pins and table
    idle();
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid reset pwmOut", int'(pwmOut), 0);
    rstN = 1'b1;
    tickEn = 1; zeroEvt = 1; cntVal = 0;
    @(negedge clk);
    check("R1 actions no-op after reset", int'(pwmOut), 0);
    check("R1 cmpA reset to 0 (R2 hit)", int'(matchA), 1);
    check("R1 cmpB reset to 0 (R2 hit)", int'(matchB), 1);
    idle();
    @(negedge clk);
    check("R2 strobe lasts one clock", int'(matchA | matchB), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule